// File: doc/BRIEF.md
# Frame Start Trigger Selector

This block decides when one direction of a synchronous serial port begins a transfer. It watches a sampled frame sync line, the start event of the opposite direction and a compare-match flag from the receive datapath. A 4-bit mode code picks which of these arms the trigger. Once a trigger is taken, a programmable number of bit-clock cycles is counted out before a single-cycle start pulse goes to the shifter. The block then stays in the transfer until the shifter reports the transfer done.

All sequential state advances only on system clock edges where `bit_tick` is high, so one bit-clock cycle is one `bit_tick` strobe. An independent period counter gives a one-cycle frame event at a fixed spacing in bit clocks. The data shifter, the clock divider and the register file are outside this block. The `IS_RX` parameter picks the receive variant, which is the only one that honours the compare-match trigger.

Top module: `frame_start_trigger`

## Requirements
- R1: While `rst` is high, `start_pulse` and `period_evt` are 0. After reset or while `enable` is low, there is no frame sync history. The first bit tick after that only records the level and is never seen as an edge.
- R2: Mode 0 starts as soon as the block is enabled and idle. It starts again on the first bit tick after the tick on which `xfer_done` ended the transfer.
- R3: Mode 1 starts on a bit tick where `opp_start` is high. With `opp_start` low, mode 1 does not start.
- R4: Mode 2 starts on a bit tick where `fsync_in` is 0. Mode 3 starts on a bit tick where `fsync_in` is 1.
- R5: Mode 4 starts on a falling edge and mode 5 on a rising edge. An edge is the `fsync_in` value at a tick compared with the value recorded at the previous tick.
- R6: Modes 6 and 7 start on either direction of `fsync_in` transition.
- R7: Mode 8 starts on a bit tick with `cmp_match` high, but only when `IS_RX`=1. Mode 8 with `IS_RX`=0 never starts. Modes 9 to 15 never start.
- R8: With start delay N, `start_pulse` is high in the clock cycle after the Nth bit tick that follows the trigger tick. With N=0 it is high in the cycle right after the trigger tick. Cycles without `bit_tick` do not count.
- R9: Triggers that arrive while a delay is counting, or while a transfer runs, are ignored. A transfer ends on a bit tick with `xfer_done` high.
- R10: While `enable` is low the block is idle and both outputs stay 0. A pending delay is dropped and no start follows after re-enable unless a new trigger comes.
- R11: With period field P≠0 and `enable` high, `period_evt` pulses once every 2×(P+1) bit ticks. The first pulse comes on the 2×(P+1)th tick after enable. With P=0 there are no pulses.
- R12: `start_pulse` is never high in two consecutive clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Direction enable; low forces idle |
| bit_tick | input | 1 | One-cycle strobe marking a bit-clock cycle |
| start_mode | input | 4 | Trigger selection code |
| start_delay | input | DELAY_W | Bit clocks from trigger to start pulse |
| period | input | PERIOD_W | Period field; 0 disables the frame event |
| fsync_in | input | 1 | Frame sync level, already synchronised |
| opp_start | input | 1 | Start event of the opposite direction |
| cmp_match | input | 1 | Received data equals compare value |
| xfer_done | input | 1 | Shifter reports the transfer finished |
| start_pulse | output | 1 | One-cycle transfer start to the shifter |
| period_evt | output | 1 | One-cycle periodic frame event |

## Verification
The bench sweeps the start delay from 0 to 7 and counts edges from trigger to pulse. An off-by-one in the counter shows up there as an early or late start, and a delay of zero that waits a full extra tick fails the first point of the sweep. Gapped bit ticks catch a counter that runs on the system clock. Extra edges injected during the delay and during the transfer catch a design that retriggers or restarts its count. Re-enabling with the sync line already high catches a design that mistakes stale history for a rising edge. The reserved codes, and the compare code on the transmit variant, are driven with every input active to show they never start. The period sweep measures both the first event and the spacing, which exposes a divider that counts P or 2P+1 ticks instead of 2(P+1).

// File: rtl/fst_pkg.sv
package fst_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        MODE_FREE   = 4'd0,
        MODE_OPP    = 4'd1,
        MODE_LOW    = 4'd2,
        MODE_HIGH   = 4'd3,
        MODE_FALL   = 4'd4,
        MODE_RISE   = 4'd5,
        MODE_CHANGE = 4'd6,
        MODE_EDGE   = 4'd7,
        MODE_CMP    = 4'd8
    } fst_mode_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } fs_flags_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } launch_state_e;

    function automatic logic is_reserved(input logic [MODE_W-1:0] code);
        return code > MODE_CMP;
    endfunction

endpackage

// File: rtl/fst_fs_sampler.sv
module fst_fs_sampler
    import fst_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en,
    input  logic      bit_tick,
    input  logic      fsync_in,
    output fs_flags_t flags
);

    logic prev_q;
    logic hist_vld;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            prev_q   <= 1'b0;
            hist_vld <= 1'b0;
        end else if (bit_tick) begin
            prev_q   <= fsync_in;
            hist_vld <= 1'b1;
        end
    end

    always_comb begin
        flags.level = fsync_in;
        flags.rise  = hist_vld & fsync_in & ~prev_q;
        flags.fall  = hist_vld & ~fsync_in & prev_q;
    end

endmodule

// File: rtl/fst_trig_mux.sv
module fst_trig_mux
    import fst_pkg::*;
#(
    parameter bit IS_RX = 1'b1
) (
    input  logic [MODE_W-1:0] mode,
    input  fs_flags_t         flags,
    input  logic              opp_start,
    input  logic              cmp_match,
    output logic              trig
);

    logic cmp_ok;

    generate
        if (IS_RX) begin : g_rx_cmp
            assign cmp_ok = cmp_match;
        end else begin : g_tx_nocmp
            assign cmp_ok = 1'b0;
        end
    endgenerate

    always_comb begin
        trig = 1'b0;
        if (!is_reserved(mode)) begin
            case (fst_mode_e'(mode))
                MODE_FREE:   trig = 1'b1;
                MODE_OPP:    trig = opp_start;
                MODE_LOW:    trig = ~flags.level;
                MODE_HIGH:   trig = flags.level;
                MODE_FALL:   trig = flags.fall;
                MODE_RISE:   trig = flags.rise;
                MODE_CHANGE: trig = flags.rise | flags.fall;
                MODE_EDGE:   trig = flags.rise | flags.fall;
                MODE_CMP:    trig = cmp_ok;
                default:     trig = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/fst_launch_seq.sv
module fst_launch_seq
    import fst_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               bit_tick,
    input  logic               trig,
    input  logic [DELAY_W-1:0] delay,
    input  logic               xfer_done,
    output logic               start_pulse
);

    launch_state_e      state_q;
    logic [DELAY_W-1:0] cnt_q;
    logic               start_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (!en) begin
                state_q <= ST_IDLE;
                cnt_q   <= '0;
            end else if (bit_tick) begin
                case (state_q)
                    ST_IDLE: begin
                        if (trig) begin
                            if (delay == '0) begin
                                start_q <= 1'b1;
                                state_q <= ST_RUN;
                            end else begin
                                cnt_q   <= delay - 1'b1;
                                state_q <= ST_WAIT;
                            end
                        end
                    end
                    ST_WAIT: begin
                        if (cnt_q == '0) begin
                            start_q <= 1'b1;
                            state_q <= ST_RUN;
                        end else begin
                            cnt_q <= cnt_q - 1'b1;
                        end
                    end
                    ST_RUN: begin
                        if (xfer_done) begin
                            state_q <= ST_IDLE;
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign start_pulse = start_q;

endmodule

// File: rtl/fst_period_gen.sv
module fst_period_gen #(
    parameter int PERIOD_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                bit_tick,
    input  logic [PERIOD_W-1:0] period,
    output logic                evt
);

    localparam int CNT_W = PERIOD_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             evt_q;

    // 2*(P+1) ticks per event: count 0 .. 2P+1
    assign limit = {period, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else if (!en || period == '0) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (bit_tick) begin
                if (cnt_q >= limit) begin
                    cnt_q <= '0;
                    evt_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign evt = evt_q;

endmodule

// File: rtl/frame_start_trigger.sv
module frame_start_trigger
    import fst_pkg::*;
#(
    parameter int DELAY_W  = 8,
    parameter int PERIOD_W = 8,
    parameter bit IS_RX    = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                enable,
    input  logic                bit_tick,
    input  logic [MODE_W-1:0]   start_mode,
    input  logic [DELAY_W-1:0]  start_delay,
    input  logic [PERIOD_W-1:0] period,
    input  logic                fsync_in,
    input  logic                opp_start,
    input  logic                cmp_match,
    input  logic                xfer_done,
    output logic                start_pulse,
    output logic                period_evt
);

    fs_flags_t fs_flags;
    logic      trig;

    fst_fs_sampler u_sampler (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .bit_tick (bit_tick),
        .fsync_in (fsync_in),
        .flags    (fs_flags)
    );

    fst_trig_mux #(.IS_RX(IS_RX)) u_mux (
        .mode      (start_mode),
        .flags     (fs_flags),
        .opp_start (opp_start),
        .cmp_match (cmp_match),
        .trig      (trig)
    );

    fst_launch_seq #(.DELAY_W(DELAY_W)) u_launch (
        .clk         (clk),
        .rst         (rst),
        .en          (enable),
        .bit_tick    (bit_tick),
        .trig        (trig),
        .delay       (start_delay),
        .xfer_done   (xfer_done),
        .start_pulse (start_pulse)
    );

    fst_period_gen #(.PERIOD_W(PERIOD_W)) u_period (
        .clk      (clk),
        .rst      (rst),
        .en       (enable),
        .bit_tick (bit_tick),
        .period   (period),
        .evt      (period_evt)
    );

endmodule

// File: rtl/fst_chk.sv
module fst_chk #(
    parameter int PERIOD_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                enable,
    input logic                bit_tick,
    input logic [PERIOD_W-1:0] period,
    input logic                start_pulse,
    input logic                period_evt
);

    // R12
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R10
    disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!start_pulse && !period_evt));

    // R8
    start_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> !start_pulse);

    // R11
    period_off_chk: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> !period_evt);

    // R11
    evt_single_chk: assert property (@(posedge clk) disable iff (rst)
        period_evt |=> !period_evt);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!start_pulse && !period_evt));

endmodule

bind frame_start_trigger fst_chk #(.PERIOD_W(PERIOD_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .enable      (enable),
    .bit_tick    (bit_tick),
    .period      (period),
    .start_pulse (start_pulse),
    .period_evt  (period_evt)
);

// File: tb/frame_start_trigger_tb_top.sv
module frame_start_trigger_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       enable = 1'b0;
    logic       bit_tick = 1'b1;
    logic [3:0] start_mode = 4'd0;
    logic [7:0] start_delay = 8'd0;
    logic [7:0] period = 8'd0;
    logic       fsync_in = 1'b0;
    logic       opp_start = 1'b0;
    logic       cmp_match = 1'b0;
    logic       xfer_done = 1'b0;
    logic       start_pulse, period_evt;
    logic       start_tx, evt_tx;

    int vec = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_start_trigger #(.DELAY_W(8), .PERIOD_W(8), .IS_RX(1'b1)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .bit_tick(bit_tick),
        .start_mode(start_mode), .start_delay(start_delay), .period(period),
        .fsync_in(fsync_in), .opp_start(opp_start), .cmp_match(cmp_match),
        .xfer_done(xfer_done), .start_pulse(start_pulse), .period_evt(period_evt)
    );

    frame_start_trigger #(.DELAY_W(8), .PERIOD_W(8), .IS_RX(1'b0)) dut_tx_i (
        .clk(clk), .rst(rst), .enable(enable), .bit_tick(bit_tick),
        .start_mode(start_mode), .start_delay(start_delay), .period(period),
        .fsync_in(fsync_in), .opp_start(opp_start), .cmp_match(cmp_match),
        .xfer_done(xfer_done), .start_pulse(start_tx), .period_evt(evt_tx)
    );

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input int act, input int exp);
        vec++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic restart(input int mode, input int dly);
        enable = 1'b0;
        cyc();
        start_mode  = mode[3:0];
        start_delay = dly[7:0];
        enable      = 1'b1;
    endtask

    task automatic finish_xfer();
        xfer_done = 1'b1;
        cyc();
        xfer_done = 1'b0;
    endtask

    // edges after the current point until start_pulse is seen (0 = already high)
    task automatic edges_to_start(input int maxc, output int m);
        m = -1;
        for (int j = 0; j <= maxc; j++) begin
            if (j > 0) cyc();
            if (start_pulse) begin
                m = j;
                break;
            end
        end
    endtask

    task automatic count_starts(input int n, output int c);
        c = 0;
        for (int j = 0; j < n; j++) begin
            cyc();
            if (start_pulse) c++;
        end
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            vec++;
            bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
            summary();
            $finish;
        end
    end

    initial begin
        int m, c, first, second;

        // R1: outputs held low through reset even with active settings
        enable = 1'b1; start_mode = 4'd0; period = 8'd1;
        for (int j = 0; j < 3; j++) begin
            cyc();
            chk("R1 start during reset", int'(start_pulse), 0);
            chk("R1 event during reset", int'(period_evt), 0);
        end
        enable = 1'b0; period = 8'd0;
        cyc();
        rst = 1'b0;
        cyc();

        // R8/R5: delay sweep with rising edge trigger, tick every cycle
        for (int n = 0; n < 8; n++) begin
            restart(5, n);
            fsync_in = 1'b0;
            count_starts(2, c);
            chk("R5 no start without edge", c, 0);
            fsync_in = 1'b1;
            cyc();
            edges_to_start(12, m);
            chk("R8 delay sweep", m, n);
            cyc();
            chk("R12 single cycle start", int'(start_pulse), 0);
            finish_xfer();
        end

        // R8: gapped bit ticks, delay 3 -> 6 clock edges
        restart(5, 3);
        fsync_in = 1'b0;
        cyc(); cyc();
        fsync_in = 1'b1;
        cyc();
        m = -1;
        for (int j = 1; j <= 12; j++) begin
            bit_tick = (j % 2 == 0);
            cyc();
            if (start_pulse && m < 0) m = j;
        end
        bit_tick = 1'b1;
        chk("R8 gapped ticks", m, 6);
        finish_xfer();

        // R1/R5: stale high level after re-enable is not an edge; falling edge mode 4
        fsync_in = 1'b1;
        restart(5, 0);
        count_starts(3, c);
        chk("R1 no edge from first sample", c, 0);
        restart(4, 0);
        count_starts(2, c);
        chk("R5 fall mode idle on high", c, 0);
        fsync_in = 1'b0;
        cyc();
        chk("R5 falling edge start", int'(start_pulse), 1);
        finish_xfer();

        // R4: level modes
        fsync_in = 1'b0;
        restart(2, 0);
        cyc();
        chk("R4 low level start", int'(start_pulse), 1);
        finish_xfer();
        cyc();
        chk("R4 low level restart", int'(start_pulse), 1);
        fsync_in = 1'b1;
        finish_xfer();
        count_starts(4, c);
        chk("R4 low mode idle on high", c, 0);
        fsync_in = 1'b0;
        restart(3, 0);
        count_starts(4, c);
        chk("R4 high mode idle on low", c, 0);
        fsync_in = 1'b1;
        cyc();
        chk("R4 high level start", int'(start_pulse), 1);
        finish_xfer();

        // R6: any-transition modes
        for (int md = 6; md <= 7; md++) begin
            fsync_in = 1'b0;
            restart(md, 0);
            count_starts(2, c);
            chk("R6 idle without change", c, 0);
            fsync_in = 1'b1;
            cyc();
            chk("R6 rise start", int'(start_pulse), 1);
            finish_xfer();
            fsync_in = 1'b0;
            cyc();
            chk("R6 fall start", int'(start_pulse), 1);
            finish_xfer();
        end

        // R3: opposite direction start
        restart(1, 0);
        count_starts(4, c);
        chk("R3 idle without opposite start", c, 0);
        opp_start = 1'b1;
        cyc();
        opp_start = 1'b0;
        chk("R3 opposite start", int'(start_pulse), 1);
        finish_xfer();

        // R7: compare trigger, receive vs transmit variant
        restart(7, 0);
        restart(8, 0);
        cmp_match = 1'b1;
        cyc();
        cmp_match = 1'b0;
        chk("R7 compare start rx", int'(start_pulse), 1);
        chk("R7 compare ignored tx", int'(start_tx), 0);
        c = 0;
        for (int j = 0; j < 4; j++) begin
            cmp_match = 1'b1;
            cyc();
            if (start_tx) c++;
        end
        cmp_match = 1'b0;
        chk("R7 tx never starts on compare", c, 0);
        finish_xfer();

        // R7: reserved codes never start
        for (int md = 9; md < 16; md++) begin
            restart(md, 0);
            c = 0;
            for (int j = 0; j < 6; j++) begin
                fsync_in  = (j % 2 == 1);
                opp_start = 1'b1;
                cmp_match = 1'b1;
                cyc();
                if (start_pulse) c++;
            end
            opp_start = 1'b0; cmp_match = 1'b0; fsync_in = 1'b0;
            chk("R7 reserved code silent", c, 0);
        end

        // R2: continuous mode
        restart(0, 0);
        cyc();
        chk("R2 start on enable", int'(start_pulse), 1);
        count_starts(5, c);
        chk("R9 no restart while running", c, 0);
        finish_xfer();
        cyc();
        chk("R2 restart after done", int'(start_pulse), 1);
        restart(0, 2);
        cyc();
        edges_to_start(8, m);
        chk("R2 continuous with delay", m, 2);
        finish_xfer();

        // R9: extra edges during delay and during transfer are ignored
        restart(5, 4);
        fsync_in = 1'b0;
        cyc(); cyc();
        fsync_in = 1'b1;
        cyc();
        m = -1; c = 0;
        for (int j = 1; j <= 12; j++) begin
            if (j == 1 || j == 6) fsync_in = 1'b0;
            if (j == 2 || j == 7) fsync_in = 1'b1;
            cyc();
            if (start_pulse) begin
                c++;
                if (m < 0) m = j;
            end
        end
        chk("R9 start position unchanged", m, 4);
        chk("R9 single start", c, 1);
        finish_xfer();

        // R10: disable aborts a pending delay
        restart(5, 5);
        fsync_in = 1'b0;
        cyc(); cyc();
        fsync_in = 1'b1;
        cyc(); cyc(); cyc();
        enable = 1'b0;
        cyc();
        chk("R10 quiet while disabled", int'(start_pulse), 0);
        enable = 1'b1;
        count_starts(10, c);
        chk("R10 pending start dropped", c, 0);

        // R11: period sweep
        start_mode = 4'd9;
        for (int p = 1; p <= 5; p++) begin
            enable = 1'b0;
            period = p[7:0];
            cyc();
            enable = 1'b1;
            first = -1; second = -1;
            for (int j = 1; j <= 4 * p + 8; j++) begin
                cyc();
                if (period_evt) begin
                    if (first < 0) first = j;
                    else if (second < 0) second = j;
                end
            end
            chk("R11 first event", first, 2 * (p + 1));
            chk("R11 event spacing", second - first, 2 * (p + 1));
        end
        period = 8'd0;
        enable = 1'b0; cyc(); enable = 1'b1;
        c = 0;
        for (int j = 0; j < 20; j++) begin
            cyc();
            if (period_evt) c++;
        end
        chk("R11 no event with zero period", c, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule